// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block merges three event sources into a single interrupt request line: a periodic tick, an alarm match and an end-of-update event. Each source arrives as a one-cycle pulse and sets a sticky flag. Each flag has its own enable bit. When a flag and its enable are both set, the interrupt line is pulled low. A summary bit in the status register shows whether any enabled flag is pending.

The host reaches the block through a small register interface with two registers. One is a control register that holds the three enables and a square-wave enable. The other is a status register that holds the flags and the summary bit. Reading the status register returns the flags and clears them in the same cycle. The interrupt line models an open-drain pin: the block either pulls it low or releases it, and never drives it high. An active-low block reset clears the enables, the square-wave enable and every flag. While that reset is held low, the block ignores all host accesses and all events.

Top module: `irq_flag_ctrl`

## Requirements
- R1: An event pulse on `ev_periodic`, `ev_alarm` or `ev_update` sets its flag on the next clock edge, whether or not the matching enable is set. The flag then holds until it is cleared.
- R2: `irq_pull` is 1 exactly when at least one flag is set together with its enable. Otherwise it is 0, meaning the line is released.
- R3: A read of the status register (address 1) returns the flag values from before the clear. That same clock edge clears every flag, and the request drops with them.
- R4: An event that arrives in the same cycle as a status read still leaves its flag set after that edge.
- R5: The status register layout is: bit 7 = summary request (OR of flag AND enable), bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update flag. Bits 3..0 read as 0.
- R6: The control register sits at address 0. Bit 2 = periodic enable, bit 1 = alarm enable, bit 0 = update enable, bit 3 = square-wave enable (also driven on `sqw_en`). Bits 7..4 read as 0. `host_rdata` is 0 when `host_rd` is low.
- R7: While `rst_n` is low, all enables, `sqw_en` and all flags are 0, and `irq_pull` is 0.
- R8: While `rst_n` is low, writes have no effect, reads return 0 and clear nothing, and event pulses set no flag.
- R9: A write to the status register, or any access to an unmapped address (2 or 3), changes no state. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of enables, square-wave enable and flags (asynchronous) |
| ev_periodic | input | 1 | One-cycle periodic tick event |
| ev_alarm | input | 1 | One-cycle alarm match event |
| ev_update | input | 1 | One-cycle end-of-update event |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | ADDR_W (2) | Register address |
| host_wdata | input | DATA_W (8) | Write data |
| host_rdata | output | DATA_W (8) | Read data, valid in the cycle of `host_rd` |
| irq_pull | output | 1 | 1 = pull the open-drain request line low, 0 = release it |
| sqw_en | output | 1 | Square-wave enable bit |

## Verification
Read data and `irq_pull` are combinational on the current register state. A read result is therefore due in the same cycle as `host_rd`. A flag set by an event, or a new enable value from a write, shows on `irq_pull` one edge after the stimulus, and so does the clear caused by a status read. Assertion of reset clears everything at once, with no edge needed. The bench sets up inputs just after the falling edge and compares all outputs one nanosecond later against a behavioural model. It updates that model only at the following rising edge. This means every comparison checks the cycle in which the result is due, not an earlier or later one.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
   // source indices: enable bit i in control, flag bit STAT_FLAG_LSB+i in status
   localparam int NSRC          = 3;
   localparam int SRC_UPD       = 0;
   localparam int SRC_ALM       = 1;
   localparam int SRC_PER       = 2;
   localparam int CTRL_SQWE_BIT = 3;
   localparam int STAT_FLAG_LSB = 4;
   localparam int STAT_IRQ_BIT  = 7;
   localparam int MIN_DATA_W    = STAT_IRQ_BIT + 1;

   typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_src_flag.sv
module irq_src_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   // set wins over clear so an event coinciding with a read survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end
endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
   import irq_flag_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 0,
   parameter int STAT_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  src_vec_t          flag_i,
   input  logic              irq_req_i,
   output src_vec_t          en_o,
   output logic              sqwe_o,
   output logic              stat_clr_o,
   output logic [DATA_W-1:0] host_rdata
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

   logic sel_ctrl, sel_stat;
   assign sel_ctrl = (host_addr == CTRL_A);
   assign sel_stat = (host_addr == STAT_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= '0;
         sqwe_o <= 1'b0;
      end else if (host_wr && sel_ctrl) begin
         en_o   <= host_wdata[NSRC-1:0];
         sqwe_o <= host_wdata[CTRL_SQWE_BIT];
      end
   end

   assign stat_clr_o = rst_n && host_rd && sel_stat;

   always_comb begin
      host_rdata = '0;
      if (rst_n && host_rd) begin
         if (sel_ctrl) begin
            host_rdata[NSRC-1:0]     = en_o;
            host_rdata[CTRL_SQWE_BIT] = sqwe_o;
         end else if (sel_stat) begin
            for (int i = 0; i < NSRC; i++)
               host_rdata[STAT_FLAG_LSB+i] = flag_i[i];
            host_rdata[STAT_IRQ_BIT] = irq_req_i;
         end
      end
   end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
   import irq_flag_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 0,
   parameter int STAT_ADDR = 1,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_periodic,
   input  logic              ev_alarm,
   input  logic              ev_update,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq_pull,
   output logic              sqw_en
);
   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("irq_flag_ctrl: DATA_W too narrow for status layout");
   end
   if (CTRL_ADDR == STAT_ADDR) begin : g_bad_addr
      $error("irq_flag_ctrl: control and status addresses collide");
   end
   if ((CTRL_ADDR >= (1 << ADDR_W)) || (STAT_ADDR >= (1 << ADDR_W))) begin : g_bad_range
      $error("irq_flag_ctrl: register address outside ADDR_W");
   end

   src_vec_t ev_vec, flag_q, en_q;
   logic     stat_clr, irq_req;

   always_comb begin
      ev_vec          = '0;
      ev_vec[SRC_PER] = ev_periodic;
      ev_vec[SRC_ALM] = ev_alarm;
      ev_vec[SRC_UPD] = ev_update;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      irq_src_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (ev_vec[i]),
         .clr_i  (stat_clr),
         .flag_o (flag_q[i])
      );
   end

   assign irq_req = |(flag_q & en_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_req;
      end
      assign irq_pull = irq_q;
   end else begin : g_irq_comb
      assign irq_pull = irq_req;
   end

   irq_host_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CTRL_ADDR (CTRL_ADDR),
      .STAT_ADDR (STAT_ADDR)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .flag_i     (flag_q),
      .irq_req_i  (irq_req),
      .en_o       (en_q),
      .sqwe_o     (sqw_en),
      .stat_clr_o (stat_clr),
      .host_rdata (host_rdata)
   );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
   import irq_flag_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 8,
   parameter int STAT_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input src_vec_t          ev_vec,
   input logic              host_rd,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_rdata,
   input logic              irq_pull,
   input logic              sqw_en,
   input src_vec_t          flag_q,
   input src_vec_t          en_q
);
   logic rd_stat;
   assign rd_stat = host_rd && (host_addr == ADDR_W'(STAT_ADDR));

   AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_vec) |=> ((flag_q & $past(ev_vec)) == $past(ev_vec))); // R1

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && ev_vec == '0) |=> (flag_q == '0)); // R3

   AST_EVENT_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && ev_vec != '0) |=> (flag_q != '0)); // R4

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stat && ev_vec == '0) |=> $stable(flag_q)); // R9

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0 && $past(en_q) == '0) |-> !irq_pull); // R2

   AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |-> (host_rdata[3:0] == 4'h0)); // R5

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_RELEASE: assert (!irq_pull && !sqw_en && host_rdata == '0); // R7
      end
   end
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .STAT_ADDR (STAT_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_vec     (ev_vec),
   .host_rd    (host_rd),
   .host_addr  (host_addr),
   .host_rdata (host_rdata),
   .irq_pull   (irq_pull),
   .sqw_en     (sqw_en),
   .flag_q     (flag_q),
   .en_q       (en_q)
);

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       ev_periodic, ev_alarm, ev_update;
   logic       host_wr, host_rd;
   logic [1:0] host_addr;
   logic [7:0] host_wdata;
   logic [7:0] host_rdata;
   logic       irq_pull, sqw_en;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // behavioural reference state
   bit m_pf, m_af, m_uf;
   bit m_pe, m_ae, m_ue, m_sq;

   always #5 clk = ~clk;

   irq_flag_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq_pull(irq_pull), .sqw_en(sqw_en)
   );

   function automatic bit model_req();
      return (m_pf && m_pe) || (m_af && m_ae) || (m_uf && m_ue);
   endfunction

   function automatic logic [7:0] model_rdata();
      logic [7:0] d = 8'h00;
      if (rst_n && host_rd) begin
         if (host_addr == 2'd0)
            d = {4'h0, m_sq, m_pe, m_ae, m_ue};
         else if (host_addr == 2'd1)
            d = {model_req(), m_pf, m_af, m_uf, 4'h0};
      end
      return d;
   endfunction

   // one clock: drive after falling edge, compare, then advance the model
   task automatic cyc(input bit r, input bit p, input bit a, input bit u,
                      input bit wr, input bit rd, input logic [1:0] ad,
                      input logic [7:0] wd, input string tag);
      logic [7:0] er;
      bit ei, es;
      @(negedge clk);
      rst_n = r; ev_periodic = p; ev_alarm = a; ev_update = u;
      host_wr = wr; host_rd = rd; host_addr = ad; host_wdata = wd;
      if (!r) begin
         m_pf = 0; m_af = 0; m_uf = 0; m_pe = 0; m_ae = 0; m_ue = 0; m_sq = 0;
      end
      #1;
      er = model_rdata();
      ei = model_req();
      es = m_sq;
      checks++;
      if (host_rdata !== er || irq_pull !== ei || sqw_en !== es) begin
         errors++;
         $display("FAIL %s: rdata=%h irq=%b sqw=%b expected rdata=%h irq=%b sqw=%b",
                  tag, host_rdata, irq_pull, sqw_en, er, ei, es);
      end
      @(posedge clk);
      if (r) begin
         bit clr = rd && (ad == 2'd1);
         if (wr && ad == 2'd0) begin
            m_ue = wd[0]; m_ae = wd[1]; m_pe = wd[2]; m_sq = wd[3];
         end
         m_pf = p || (m_pf && !clr);
         m_af = a || (m_af && !clr);
         m_uf = u || (m_uf && !clr);
      end
   endtask

   task automatic idle(input string tag);
      cyc(1, 0, 0, 0, 0, 0, 2'd0, 8'h00, tag);
   endtask

   task automatic rd_stat(input string tag);
      cyc(1, 0, 0, 0, 0, 1, 2'd1, 8'h00, tag);
   endtask

   task automatic rd_ctrl(input string tag);
      cyc(1, 0, 0, 0, 0, 1, 2'd0, 8'h00, tag);
   endtask

   task automatic wr_ctrl(input logic [7:0] v, input string tag);
      cyc(1, 0, 0, 0, 1, 0, 2'd0, v, tag);
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; ev_periodic = 0; ev_alarm = 0; ev_update = 0;
      host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
      // R7: reset state
      cyc(0, 0, 0, 0, 0, 0, 2'd0, 8'h00, "R7");
      cyc(0, 0, 0, 0, 0, 1, 2'd1, 8'h00, "R7");
      idle("R7");
      rd_ctrl("R6");
      // R1: event sets flag with enable clear, no request
      cyc(1, 0, 1, 0, 0, 0, 2'd0, 8'h00, "R1");
      idle("R1");
      // R3 / R5: read returns old flags then clears
      rd_stat("R3");
      rd_stat("R3");
      cyc(1, 1, 0, 1, 0, 0, 2'd0, 8'h00, "R1");
      rd_stat("R5");
      // R6: control layout
      wr_ctrl(8'hFF, "R6");
      rd_ctrl("R6");
      // R2: enabled source drives the line
      cyc(1, 1, 0, 0, 0, 0, 2'd0, 8'h00, "R2");
      idle("R2");
      rd_stat("R2");
      idle("R2");
      // R2: masked source stays quiet, unmasking raises request
      wr_ctrl(8'h08, "R2");
      cyc(1, 0, 0, 1, 0, 0, 2'd0, 8'h00, "R2");
      idle("R2");
      wr_ctrl(8'h01, "R2");
      idle("R2");
      rd_stat("R2");
      idle("R2");
      // R4: event during status read survives
      wr_ctrl(8'h07, "R4");
      cyc(1, 0, 0, 1, 0, 0, 2'd0, 8'h00, "R4");
      cyc(1, 0, 1, 0, 0, 1, 2'd1, 8'h00, "R4");
      rd_stat("R4");
      rd_stat("R4");
      // R9: status write and unmapped accesses change nothing
      cyc(1, 1, 0, 0, 0, 0, 2'd0, 8'h00, "R9");
      cyc(1, 0, 0, 0, 1, 0, 2'd1, 8'hFF, "R9");
      cyc(1, 0, 0, 0, 1, 0, 2'd2, 8'h00, "R9");
      cyc(1, 0, 0, 0, 0, 1, 2'd3, 8'h00, "R9");
      rd_ctrl("R9");
      rd_stat("R9");
      // R7 / R8: reset mid-run clears state and blocks access
      wr_ctrl(8'h0F, "R7");
      cyc(1, 1, 1, 1, 0, 0, 2'd0, 8'h00, "R7");
      cyc(0, 0, 0, 0, 0, 0, 2'd0, 8'h00, "R7");
      cyc(0, 0, 0, 0, 1, 0, 2'd0, 8'h0F, "R8");
      cyc(0, 1, 1, 1, 0, 0, 2'd0, 8'h00, "R8");
      cyc(0, 0, 0, 0, 0, 1, 2'd0, 8'h00, "R8");
      idle("R8");
      rd_ctrl("R8");
      rd_stat("R8");
      idle("R8");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule